// File: doc/BRIEF.md
# Range-Masked Register Bank Update

This block turns a pair of one-hot position markers into a contiguous write-enable mask and uses that mask to update a register bank of the same width. The mask covers every bit from the higher marker down to the lower marker, with both end positions set. On a load strobe, only the bank bits inside that range take the matching bits of the data input. Every other bit keeps its stored value.

The mask comes from arithmetic, not from a scan. The two markers are compared as unsigned numbers and the smaller is subtracted from the larger. The difference sets every bit strictly below the higher marker down to the lower one, and ORing in the higher marker closes the range at the top. The markers can arrive in either order. A marker that is zero, or has more than one bit set, raises an error flag in the same cycle, forces the mask to zero and blocks the bank update. The mask used by the most recent load is held in a register and driven out next to the bank.

Top module: `range_bank_upd`

## Requirements
- R1: `err_o` is high in the same cycle, combinationally, whenever `start_i` or `end_i` does not have exactly one bit set. An all-zero marker and a marker with two or more bits set both count.
- R2: With valid markers and `start_i` at a higher bit position than `end_i`, the applied mask has ones at every bit position from the `start_i` position down to the `end_i` position, both included, and zeros elsewhere. Example: positions 6 and 1 of a 9-bit vector give 9'b0_0111_1110.
- R3: Swapping the markers (`start_i` at a lower position than `end_i`) gives the same inclusive mask as the unswapped pair.
- R4: When both markers select the same bit position, the mask is that single bit.
- R5: On a rising clock edge with `load_i` high, bank bits inside the mask take the matching `data_i` bits. Bank bits outside the mask keep their value.
- R6: On a rising clock edge with `load_i` low, both `bank_o` and `mask_o` keep their values, whatever the marker and data inputs are.
- R7: A load with an invalid marker (see R1) changes no bank bit, and `mask_o` becomes all zeros.
- R8: `mask_o` shows the mask applied by the most recent load from the clock edge that performs that load onward. It is readable one cycle after the strobe.
- R9: `rst_ni` low clears `bank_o` and `mask_o` to zero asynchronously, without waiting for a clock edge.
- R10: Ranges that touch bit 0 and bit N-1 are handled with no carry beyond the top bit. Positions N-1 and 0 give an all-ones mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | N | One-hot marker for one end of the range |
| end_i | input | N | One-hot marker for the other end of the range |
| load_i | input | 1 | Load strobe for the bank |
| data_i | input | N | New data for the bank bits inside the range |
| bank_o | output | N | Register bank contents |
| mask_o | output | N | Mask applied by the most recent load |
| err_o | output | 1 | Marker validity error, combinational |

## Verification
The bench builds the block at N = 9. That width is small enough that directed cases can place the markers on bit 0, on the top bit, on the same bit and in both orders, and still leave interior ranges that exclude both ends. A pseudo-random phase then draws marker positions, load strobes, data and occasional malformed markers over several hundred cycles. This covers many start/end pairs in both orders and checks the hold behaviour of the bits outside each range.

// File: rtl/range_mask_pkg.sv
package range_mask_pkg;
  // default bank width
  localparam int unsigned RB_DEF_W = 9;
  // index of the two markers in the marker array
  typedef enum logic {MK_START = 1'b0, MK_END = 1'b1} marker_e;
endpackage

// File: rtl/onehot_check.sv
module onehot_check #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] vec_i,
  output logic         ok_o
);
  logic nonzero;
  logic single;

  always_comb begin
    nonzero = |vec_i;
    // clearing the lowest set bit leaves zero only for a single bit
    single  = ((vec_i & (vec_i - N'(1))) == '0);
    ok_o    = nonzero && single;
  end
endmodule

// File: rtl/range_mask_gen.sv
module range_mask_gen #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] start_i,
  input  logic [N-1:0] end_i,
  input  logic         valid_i,
  output logic [N-1:0] mask_o
);
  logic         swap;
  logic [N-1:0] hi;
  logic [N-1:0] lo;
  logic [N-1:0] diff;

  always_comb begin
    swap   = (start_i < end_i);
    hi     = swap ? end_i   : start_i;
    lo     = swap ? start_i : end_i;
    // hi - lo sets bits [hi_pos-1 : lo_pos]; OR in hi to close the range
    diff   = hi - lo;
    mask_o = valid_i ? (diff | hi) : '0;
  end
endmodule

// File: rtl/masked_bank.sv
module masked_bank #(
  parameter int unsigned N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] bit_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 bit_q[g] <= 1'b0;
      else if (load_i && en_i[g])  bit_q[g] <= data_i[g];
    end
  end

  assign q_o = bit_q;
endmodule

// File: rtl/range_bank_upd.sv
module range_bank_upd
  import range_mask_pkg::*;
#(
  parameter int unsigned N = RB_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] start_i,
  input  logic [N-1:0] end_i,
  input  logic         load_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] bank_o,
  output logic [N-1:0] mask_o,
  output logic         err_o
);
  localparam int unsigned NMK = 2;

  logic [N-1:0]   mk   [NMK];
  logic [NMK-1:0] mk_ok;
  logic           pair_ok;
  logic [N-1:0]   mask_d;
  logic [N-1:0]   mask_q;

  assign mk[MK_START] = start_i;
  assign mk[MK_END]   = end_i;

  for (genvar m = 0; m < NMK; m++) begin : g_chk
    onehot_check #(.N(N)) u_chk (
      .vec_i (mk[m]),
      .ok_o  (mk_ok[m])
    );
  end

  assign pair_ok = &mk_ok;
  assign err_o   = !pair_ok;

  range_mask_gen #(.N(N)) u_gen (
    .start_i (start_i),
    .end_i   (end_i),
    .valid_i (pair_ok),
    .mask_o  (mask_d)
  );

  masked_bank #(.N(N)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .en_i   (mask_d),
    .data_i (data_i),
    .q_o    (bank_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/range_bank_upd_chk.sv
module range_bank_upd_chk #(
  parameter int unsigned N = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] start_i,
  input logic [N-1:0] end_i,
  input logic         load_i,
  input logic [N-1:0] data_i,
  input logic [N-1:0] bank_o,
  input logic [N-1:0] mask_o,
  input logic         err_o
);
  assert_err_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == !($onehot(start_i) && $onehot(end_i)));

  assert_hold_outside_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (((bank_o ^ $past(bank_o)) & ~mask_o) == '0));

  assert_load_inside_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (((bank_o ^ $past(data_i)) & mask_o) == '0));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(bank_o) && $stable(mask_o)));

  assert_bad_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && err_o) |=> ($stable(bank_o) && (mask_o == '0)));

  assert_mask_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !err_o) |=>
      (((mask_o & $past(start_i)) != '0) && ((mask_o & $past(end_i)) != '0)));

  assert_equal_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !err_o && (start_i == end_i)) |=> ($countones(mask_o) == 1));
endmodule

bind range_bank_upd range_bank_upd_chk #(.N(N)) u_chk_bind (.*);

// File: tb/range_bank_upd_tb.sv
`timescale 1ns/1ps
module range_bank_upd_tb;
  localparam int N = 9;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [N-1:0] start_i, end_i, data_i;
  logic         load_i;
  logic [N-1:0] bank_o, mask_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_bank, m_mask;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  range_bank_upd #(.N(N)) u_dut (.*);

  function automatic logic [N-1:0] ref_mask(logic [N-1:0] s, logic [N-1:0] e);
    int ps = -1, pe = -1, cs = 0, ce = 0, lo, hi;
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      if (s[i]) begin cs++; ps = i; end
      if (e[i]) begin ce++; pe = i; end
    end
    if (cs != 1 || ce != 1) return '0;
    lo = (ps < pe) ? ps : pe;
    hi = (ps < pe) ? pe : ps;
    for (int i = lo; i <= hi; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic bit ref_err(logic [N-1:0] s, logic [N-1:0] e);
    return ($countones(s) != 1) || ($countones(e) != 1);
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // called at negedge: drive, check err, clock, check state
  task automatic cyc(string req, logic [N-1:0] s, logic [N-1:0] e,
                     logic ld, logic [N-1:0] d);
    logic [N-1:0] m;
    start_i = s; end_i = e; load_i = ld; data_i = d;
    #1;
    chk({req, " R1 err"}, N'(err_o), N'(ref_err(s, e)));
    m = ref_mask(s, e);
    @(posedge clk_i);
    if (ld) begin
      m_bank = (m_bank & ~m) | (d & m);
      m_mask = m;
    end
    @(negedge clk_i);
    chk({req, " bank"}, bank_o, m_bank);
    chk({req, " mask"}, mask_o, m_mask);
  endtask

  function automatic logic [N-1:0] bitp(int p);
    return N'(1) << p;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    rst_ni = 1'b0; start_i = '0; end_i = '0; load_i = 0; data_i = '0;
    m_bank = '0; m_mask = '0;
    repeat (2) @(negedge clk_i);
    chk("R9 reset bank", bank_o, '0);
    chk("R9 reset mask", mask_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cyc("R2 6..1 ones", bitp(6), bitp(1), 1, '1);
    chk("R2 example", mask_o, 9'b0_0111_1110);
    cyc("R3 swapped 1..6", bitp(1), bitp(6), 1, '0);
    chk("R3 same mask", mask_o, 9'b0_0111_1110);
    cyc("R4 equal 3", bitp(3), bitp(3), 1, '1);
    chk("R4 single", mask_o, 9'b0_0000_1000);
    cyc("R6 no load", bitp(8), bitp(0), 0, '1);
    cyc("R1 R7 zero start", '0, bitp(2), 1, '1);
    chk("R7 mask zero", mask_o, '0);
    cyc("R1 R7 two bits", bitp(5) | bitp(2), bitp(0), 1, '1);
    cyc("R10 full 8..0", bitp(8), bitp(0), 1, 9'h155);
    chk("R10 all ones", mask_o, '1);
    cyc("R10 swapped 0..8", bitp(0), bitp(8), 1, 9'h0AA);
    cyc("R10 top only", bitp(8), bitp(8), 1, '0);
    cyc("R10 bottom only", bitp(0), bitp(0), 1, '0);
    cyc("R8 after idle", bitp(7), bitp(4), 1, 9'h1F0);
    cyc("R6 idle bad marks", '0, '0, 0, '0);

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] s, e;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      s = bitp(lf[3:0] % N);
      e = bitp(lf[7:4] % N);
      if (lf[12:10] == 3'd0) s = s | bitp(lf[16:13] % N);
      if (lf[12:10] == 3'd1) e = '0;
      cyc("R5 random", s, e, lf[8] | lf[9], lf[28:20]);
    end

    // asynchronous reset between edges
    #1 rst_ni = 1'b0;
    #1;
    m_bank = '0; m_mask = '0;
    chk("R9 async bank", bank_o, '0);
    chk("R9 async mask", mask_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cyc("R5 post reset", bitp(2), bitp(5), 1, '1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule